// File: doc/BRIEF.md
# Sixteen-Operation Data-Processing ALU

This block is the combinational arithmetic and logic stage of a 32-bit processor's data-processing path. It takes the 4-bit operation code from instruction bits 24:21, the first operand, the already-shifted second operand, the current carry and overflow flags, and the carry-out of the operand shifter. It returns the result word, a write strobe for the destination register, and the proposed values of the four condition flags.

There are sixteen operations:
- Plain and reversed subtraction, each with an optional carry-in.
- Addition, with an optional carry-in.
- Four bitwise operations.
- Two moves, which ignore the first operand.
- Four compare and test operations, which update only the flags.

The surrounding pipeline does everything else. It chooses and shifts the second operand, decides whether the flags are committed, and holds the flag register.

Top module: `dp_alu`

## Requirements
- R1: The bitwise codes give these results: 0000 gives Rn AND Op2, 0001 gives Rn XOR Op2, 1100 gives Rn OR Op2, and 1110 gives Rn AND NOT Op2.
- R2: Code 1101 gives Op2 and code 1111 gives NOT Op2. In both cases the value of Rn has no effect on any output.
- R3: Code 0100 gives Rn+Op2 and code 0101 gives Rn+Op2+C, both modulo 2^32. C is the carry out of bit 31.
- R4: Code 0010 gives Rn−Op2 and code 0011 gives Op2−Rn. C is 1 exactly when no borrow occurs, that is, when the minuend is greater than or equal to the subtrahend.
- R5: Code 0110 gives Rn−Op2+C−1 and code 0111 gives Op2−Rn+C−1. C is 1 exactly when the exact value of that expression is not negative.
- R6: The write strobe is 0 for codes 1000 to 1011 and 1 for every other code. Codes 1010 and 1011 produce the flags of Rn−Op2 and Rn+Op2 respectively.
- R7: N equals bit 31 of the result. Z is 1 exactly when all 32 result bits are 0.
- R8: For the eight arithmetic codes (0010–0111, 1010, 1011), V is 1 exactly when the exact signed value of the operation lies outside the range −2^31 to 2^31−1.
- R9: For the eight bitwise and move codes (0000, 0001, 1000, 1001, 1100–1111), C equals the shifter carry-out input and V equals the incoming V flag.
- R10: Codes 1000 and 1001 produce the flags of Rn AND Op2 and of Rn XOR Op2 respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cmd_i | input | 4 | Operation code (instruction bits 24:21) |
| rn_i | input | 32 | First operand |
| op2_i | input | 32 | Second operand, after the shifter |
| carry_i | input | 1 | Current C flag |
| ovf_i | input | 1 | Current V flag |
| shift_carry_i | input | 1 | Carry-out of the operand shifter |
| result_o | output | 32 | Operation result |
| wr_en_o | output | 1 | Destination register write strobe |
| flag_n_o | output | 1 | Proposed N flag |
| flag_z_o | output | 1 | Proposed Z flag |
| flag_c_o | output | 1 | Proposed C flag |
| flag_v_o | output | 1 | Proposed V flag |

## Verification
The embedded assertions check the following on every evaluation:
- The write strobe follows the compare/test class of the code.
- N and Z agree with the result word.
- For bitwise codes, C and V are passed through from their inputs.
- A move returns the second operand.

The arithmetic values themselves can only be shown by the bench's scenarios. These are the sums, differences, carry-in variants, borrow-derived carries and signed overflow. The bench compares each of them against an integer-width reference, using directed boundary operands and a random sweep. The scenarios also show that Rn has no effect on the moves.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'b0000, OP_EOR = 4'b0001, OP_SUB = 4'b0010, OP_RSB = 4'b0011,
    OP_ADD = 4'b0100, OP_ADC = 4'b0101, OP_SBC = 4'b0110, OP_RSC = 4'b0111,
    OP_TST = 4'b1000, OP_TEQ = 4'b1001, OP_CMP = 4'b1010, OP_CMN = 4'b1011,
    OP_ORR = 4'b1100, OP_MOV = 4'b1101, OP_BIC = 4'b1110, OP_MVN = 4'b1111
  } alu_op_e;

  // Arithmetic class: the adder result and its carry/overflow drive the flags.
  function automatic logic op_is_arith(input logic [3:0] op);
    case (alu_op_e'(op))
      OP_SUB, OP_RSB, OP_ADD, OP_ADC,
      OP_SBC, OP_RSC, OP_CMP, OP_CMN: op_is_arith = 1'b1;
      default:                        op_is_arith = 1'b0;
    endcase
  endfunction

  // Compare/test class: flags only, no destination write.
  function automatic logic op_is_flag_only(input logic [3:0] op);
    op_is_flag_only = (op[3:2] == 2'b10);
  endfunction

endpackage

// File: rtl/dp_operand_route.sv
module dp_operand_route
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [3:0]       op_i,
  input  logic [WIDTH-1:0] rn_i,
  input  logic [WIDTH-1:0] op2_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] add_a_o,
  output logic [WIDTH-1:0] add_b_o,
  output logic             add_cin_o
);

  // Subtraction is performed as a + ~b + cin, so the adder's carry-out is the
  // inverted borrow without any extra logic.
  always_comb begin
    add_a_o   = rn_i;
    add_b_o   = op2_i;
    add_cin_o = 1'b0;
    case (alu_op_e'(op_i))
      OP_SUB, OP_CMP: begin add_b_o = ~op2_i; add_cin_o = 1'b1; end
      OP_RSB:         begin add_a_o = op2_i; add_b_o = ~rn_i; add_cin_o = 1'b1; end
      OP_ADC:         add_cin_o = carry_i;
      OP_SBC:         begin add_b_o = ~op2_i; add_cin_o = carry_i; end
      OP_RSC:         begin add_a_o = op2_i; add_b_o = ~rn_i; add_cin_o = carry_i; end
      default:        ;
    endcase
  end

endmodule

// File: rtl/dp_adder.sv
module dp_adder #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             ovf_o
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0] wide_sum;

  always_comb begin
    wide_sum = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};
    sum_o    = wide_sum[MSB:0];
    cout_o   = wide_sum[WIDTH];
    // Signed overflow: operands share a sign that the sum does not.
    ovf_o    = (a_i[MSB] == b_i[MSB]) && (sum_o[MSB] != a_i[MSB]);
  end

endmodule

// File: rtl/dp_logic_unit.sv
module dp_logic_unit
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [3:0]       op_i,
  input  logic [WIDTH-1:0] rn_i,
  input  logic [WIDTH-1:0] op2_i,
  output logic [WIDTH-1:0] res_o
);

  always_comb begin
    case (alu_op_e'(op_i))
      OP_AND, OP_TST: res_o = rn_i & op2_i;
      OP_EOR, OP_TEQ: res_o = rn_i ^ op2_i;
      OP_ORR:         res_o = rn_i | op2_i;
      OP_MOV:         res_o = op2_i;
      OP_BIC:         res_o = rn_i & ~op2_i;
      OP_MVN:         res_o = ~op2_i;
      default:        res_o = '0;
    endcase
  end

endmodule

// File: rtl/dp_flag_gen.sv
module dp_flag_gen #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] result_i,
  input  logic             arith_i,
  input  logic             add_cout_i,
  input  logic             add_ovf_i,
  input  logic             shift_carry_i,
  input  logic             ovf_i,
  output logic             n_o,
  output logic             z_o,
  output logic             c_o,
  output logic             v_o
);

  always_comb begin
    n_o = result_i[WIDTH-1];
    z_o = ~|result_i;
    c_o = arith_i ? add_cout_i : shift_carry_i;
    v_o = arith_i ? add_ovf_i  : ovf_i;
  end

endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [3:0]       cmd_i,
  input  logic [WIDTH-1:0] rn_i,
  input  logic [WIDTH-1:0] op2_i,
  input  logic             carry_i,
  input  logic             ovf_i,
  input  logic             shift_carry_i,
  output logic [WIDTH-1:0] result_o,
  output logic             wr_en_o,
  output logic             flag_n_o,
  output logic             flag_z_o,
  output logic             flag_c_o,
  output logic             flag_v_o
);

  localparam int MSB = WIDTH - 1;

  // Named internal events, visible to the assertions below.
  logic [WIDTH-1:0] add_a, add_b, add_sum, logic_res;
  logic             add_cin, add_cout, add_ovf;
  logic             is_arith, is_flag_only;

  assign is_arith     = op_is_arith(cmd_i);
  assign is_flag_only = op_is_flag_only(cmd_i);

  dp_operand_route #(.WIDTH(WIDTH)) u_route (
    .op_i(cmd_i), .rn_i(rn_i), .op2_i(op2_i), .carry_i(carry_i),
    .add_a_o(add_a), .add_b_o(add_b), .add_cin_o(add_cin)
  );

  dp_adder #(.WIDTH(WIDTH)) u_adder (
    .a_i(add_a), .b_i(add_b), .cin_i(add_cin),
    .sum_o(add_sum), .cout_o(add_cout), .ovf_o(add_ovf)
  );

  dp_logic_unit #(.WIDTH(WIDTH)) u_logic (
    .op_i(cmd_i), .rn_i(rn_i), .op2_i(op2_i), .res_o(logic_res)
  );

  assign result_o = is_arith ? add_sum : logic_res;
  assign wr_en_o  = ~is_flag_only;

  dp_flag_gen #(.WIDTH(WIDTH)) u_flags (
    .result_i(result_o), .arith_i(is_arith),
    .add_cout_i(add_cout), .add_ovf_i(add_ovf),
    .shift_carry_i(shift_carry_i), .ovf_i(ovf_i),
    .n_o(flag_n_o), .z_o(flag_z_o), .c_o(flag_c_o), .v_o(flag_v_o)
  );

  // Checks on every evaluation of the combinational outputs.
  always_comb begin
    // R6: compare/test codes (1000..1011) never write the destination
    a_r6_no_write: assert (wr_en_o == !(cmd_i >= 4'b1000 && cmd_i <= 4'b1011));
    // R7: N mirrors the top result bit, Z the all-zero result
    a_r7_n_flag: assert (flag_n_o == result_o[MSB]);
    a_r7_z_flag: assert (flag_z_o == (result_o == '0));
    // R9: bitwise/move codes pass shifter carry and old V through
    if (!is_arith) begin
      a_r9_logic_carry: assert (flag_c_o == shift_carry_i);
      a_r9_logic_ovf:   assert (flag_v_o == ovf_i);
    end
    // R2: move returns the second operand unchanged
    if (cmd_i == 4'b1101) begin
      a_r2_mov_passes_op2: assert (result_o == op2_i);
    end
  end

endmodule

// File: tb/dp_alu_bench.sv
module dp_alu_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cmd = '0;
  logic [31:0] rn = '0, op2 = '0;
  logic        cin = 1'b0, vin = 1'b0, scin = 1'b0;
  logic [31:0] result;
  logic        wr_en, fn, fz, fc, fv;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  dp_alu u_dp_alu (
    .cmd_i(cmd), .rn_i(rn), .op2_i(op2), .carry_i(cin), .ovf_i(vin),
    .shift_carry_i(scin), .result_o(result), .wr_en_o(wr_en),
    .flag_n_o(fn), .flag_z_o(fz), .flag_c_o(fc), .flag_v_o(fv)
  );

  // Behavioural reference using 64-bit integers.
  function automatic logic [36:0] ref_model(input logic [3:0] k, input logic [31:0] a,
                                           input logic [31:0] b, input logic c,
                                           input logic v, input logic sc);
    longint ua = longint'({32'b0, a});
    longint ub = longint'({32'b0, b});
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    longint ci = c ? 1 : 0;
    longint u = 0, s = 0;
    logic [31:0] r = '0;
    logic arith = 1'b1, sub = 1'b0, cc, vv;
    case (k)
      4'd2, 4'd10: begin u = ua - ub;          s = sa - sb;          sub = 1'b1; end
      4'd3:        begin u = ub - ua;          s = sb - sa;          sub = 1'b1; end
      4'd4, 4'd11: begin u = ua + ub;          s = sa + sb;                      end
      4'd5:        begin u = ua + ub + ci;     s = sa + sb + ci;                 end
      4'd6:        begin u = ua - ub + ci - 1; s = sa - sb + ci - 1; sub = 1'b1; end
      4'd7:        begin u = ub - ua + ci - 1; s = sb - sa + ci - 1; sub = 1'b1; end
      default: arith = 1'b0;
    endcase
    if (arith) begin
      r  = u[31:0];
      cc = sub ? (u >= 0) : (u >= 64'sd4294967296);
      vv = (s > 64'sd2147483647) || (s < -64'sd2147483648);
    end else begin
      case (k)
        4'd0, 4'd8: r = a & b;
        4'd1, 4'd9: r = a ^ b;
        4'd12:      r = a | b;
        4'd13:      r = b;
        4'd14:      r = a & ~b;
        default:    r = ~b;
      endcase
      cc = sc;
      vv = v;
    end
    ref_model = {!(k >= 8 && k <= 11), r[31], (r == 0), cc, vv, r};
  endfunction

  task automatic check(input string tag);
    logic [36:0] exp, act;
    exp = ref_model(cmd, rn, op2, cin, vin, scin);
    act = {wr_en, fn, fz, fc, fv, result};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cmd=%b rn=%h op2=%h c=%b: actual=%h expected=%h",
               tag, cmd, rn, op2, cin, act, exp);
    end
  endtask

  // Drive just after a rising edge, compare at the following falling edge.
  task automatic apply(input logic [3:0] k, input logic [31:0] a, input logic [31:0] b,
                       input logic c, input logic v, input logic sc, input string tag);
    @(posedge clk); #1;
    cmd = k; rn = a; op2 = b; cin = c; vin = v; scin = sc;
    @(negedge clk);
    check(tag);
  endtask

  function automatic string tag_of(input logic [3:0] k);
    case (k)
      4'd0, 4'd1, 4'd12, 4'd14: tag_of = "R1";
      4'd13, 4'd15:             tag_of = "R2";
      4'd4, 4'd5:               tag_of = "R3";
      4'd2, 4'd3:               tag_of = "R4";
      4'd6, 4'd7:               tag_of = "R5";
      4'd8, 4'd9:               tag_of = "R10";
      default:                  tag_of = "R6";
    endcase
  endfunction

  initial begin : watchdog
    #1000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stimulus
    // Reset state: all-zero inputs give AND of zeros, result 0, Z set (R7).
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7");

    // R1: bitwise operations
    apply(4'b0000, 32'hF0F0_1234, 32'h0FF0_FFFF, 0, 1, 1, "R1");
    apply(4'b0001, 32'hAAAA_5555, 32'hFFFF_0000, 1, 0, 0, "R1");
    apply(4'b1100, 32'h8000_0000, 32'h0000_0001, 0, 0, 1, "R1");
    apply(4'b1110, 32'hFFFF_FFFF, 32'h0000_FF00, 0, 1, 0, "R1");
    // R2: moves ignore Rn (same Op2, different Rn, same outputs)
    apply(4'b1101, 32'h0000_0000, 32'hDEAD_BEEF, 0, 0, 1, "R2");
    apply(4'b1101, 32'hFFFF_FFFF, 32'hDEAD_BEEF, 0, 0, 1, "R2");
    apply(4'b1111, 32'h1234_5678, 32'hFFFF_FFFF, 1, 1, 0, "R2");
    apply(4'b1111, 32'h8765_4321, 32'hFFFF_FFFF, 1, 1, 0, "R2");
    // R3: additions, carry out of bit 31
    apply(4'b0100, 32'hFFFF_FFFF, 32'h0000_0001, 0, 0, 0, "R3");
    apply(4'b0101, 32'hFFFF_FFFE, 32'h0000_0001, 1, 0, 0, "R3");
    apply(4'b0101, 32'h0000_0005, 32'h0000_0007, 0, 0, 1, "R3");
    // R4: subtractions, C = not borrow, equal operands give C=1 and Z=1
    apply(4'b0010, 32'h0000_0010, 32'h0000_0010, 0, 0, 0, "R4");
    apply(4'b0010, 32'h0000_0001, 32'h0000_0002, 1, 0, 1, "R4");
    apply(4'b0011, 32'h0000_0003, 32'h0000_0FF0, 0, 0, 0, "R4");
    // R5: carry-in subtractions
    apply(4'b0110, 32'h0000_0005, 32'h0000_0005, 0, 0, 0, "R5");
    apply(4'b0110, 32'h0000_0005, 32'h0000_0005, 1, 0, 0, "R5");
    apply(4'b0111, 32'h0000_0000, 32'h0000_0000, 0, 1, 1, "R5");
    // R8: signed overflow boundaries
    apply(4'b0100, 32'h7FFF_FFFF, 32'h0000_0001, 0, 0, 0, "R8");
    apply(4'b0010, 32'h8000_0000, 32'h0000_0001, 0, 0, 0, "R8");
    apply(4'b0011, 32'h0000_0001, 32'h8000_0000, 0, 0, 0, "R8");
    apply(4'b1011, 32'h8000_0000, 32'h8000_0000, 0, 0, 0, "R8");
    // R6: compares suppress the write and keep arithmetic flags
    apply(4'b1010, 32'h0000_0007, 32'h0000_0009, 0, 1, 1, "R6");
    apply(4'b1011, 32'hFFFF_FFF9, 32'h0000_0007, 0, 1, 1, "R6");
    // R10: tests give flags of AND / XOR
    apply(4'b1000, 32'hF000_0000, 32'h0F00_0000, 1, 1, 1, "R10");
    apply(4'b1001, 32'h8000_0001, 32'h0000_0001, 0, 0, 0, "R10");
    // R9: bitwise C/V pass through both polarities
    apply(4'b1100, 32'h0, 32'h0, 1, 1, 0, "R9");
    apply(4'b1100, 32'h0, 32'h0, 0, 0, 1, "R9");

    // Random sweep over every code
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] k;
      k = 4'($urandom_range(0, 15));
      apply(k, $urandom, (i % 4 == 0) ? 32'($urandom_range(0, 3)) : $urandom,
            1'($urandom), 1'($urandom), 1'($urandom), tag_of(k));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule